// File: doc/BRIEF.md
# External Bus Release Arbiter

This block lets an external bus master take over an external memory bus that has a synchronous DRAM on it. The master asks for the bus by pulling an active-low request input low. The arbiter lets any external access in progress run to its end. It then sends a precharge-all command to the DRAM, followed by one or more no-operation cycles. Only after that does it drop its active-low acknowledge output and switch off its drivers for the address, data and DRAM control pins.

While the bus is released, the arbiter keeps sampling the request input. When the request goes high, the acknowledge goes high again. The drivers are switched back on one state later. During the release, an active-low request-out pin tells the external master that internal logic wants the bus back. This happens when an internal master has an access pending or a refresh is due, and only while the enable input is set. When the request-out was caused by an access, it returns high one and a half states after the acknowledge rises. When it was caused by a refresh, it stays low until the refresh cycle actually begins.

Top module: `ext_bus_release`

## Requirements
- R1: `breq_n` is sampled on the rising edge of `clk` and a low level is a request. While the bus is idle and `breq_n` is high, `back_n` stays 1, `bus_oe` stays 1 and `sdram_cmd` stays NOP.
- R2: After the request edge, the arbiter waits while `access_busy` is sampled 1. `sdram_cmd` shows PALL in the state that follows the first rising edge at which `access_busy` is sampled 0.
- R3: `sdram_cmd` is {RAS_n, CAS_n, WE_n}, with NOP = 3'b111 and PALL = 3'b010. PALL is followed by POST_NOPS states of NOP. Counting from the request edge, `back_n` falls at edge k+2+POST_NOPS, where k is the number of busy edges. This is never fewer than two states after the request.
- R4: While `back_n` is 0, `bus_oe` is 0, so every bus and DRAM pin is high impedance.
- R5: `breq_n` is still sampled during the release. `back_n` stays 0 while `breq_n` is sampled low. `back_n` rises on the edge that samples `breq_n` high. `bus_oe` returns to 1 one state later.
- R6: While the bus is released and `reqout_en` is 1, `reqout_n` falls half a state after an edge that samples `int_access_req` or `refresh_req` at 1.
- R7: When the request-out was caused by an access request only, `reqout_n` rises 1.5 states after `back_n` rises. It is still 0 half a state before that point.
- R8: When a refresh request was seen during the release, `reqout_n` stays 0 after the release ends. It rises half a state after the edge that samples `refresh_start` at 1.
- R9: While `reqout_en` is 0, `reqout_n` stays 1 whatever requests are pending.
- R10: After reset, `back_n` = 1, `bus_oe` = 1, `sdram_cmd` = NOP and `reqout_n` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| breq_n | input | 1 | Bus request from the external master, active low |
| access_busy | input | 1 | An external access cycle is still in progress |
| int_access_req | input | 1 | An internal master needs an external access |
| refresh_req | input | 1 | An auto-refresh is pending |
| refresh_start | input | 1 | The auto-refresh cycle begins |
| reqout_en | input | 1 | Enables the request-out signal |
| back_n | output | 1 | Bus acknowledge to the external master, active low |
| reqout_n | output | 1 | Request-out to the external master, active low |
| bus_oe | output | 1 | Enable for the address, data and DRAM control drivers |
| sdram_cmd | output | 3 | DRAM command {RAS_n, CAS_n, WE_n} |

## Verification
Count the request edge as edge 0. The PALL state then begins at edge k+1, the acknowledge falls at edge k+2+POST_NOPS, and the drivers come back one edge after the acknowledge rises. The bench samples these outputs 5 ns after each rising edge.

The request-out is set by a falling-edge register, so its changes land half a state after the edge that decides them. The bench samples it 15 ns after the edge. At the 1.5-state point it is sampled on both sides of the falling edge.

A sweep over busy length, enable and request cause computes each expected state from these offsets.

// File: rtl/ebr_pkg.sv
package ebr_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT,
      ST_PALL,
      ST_POST,
      ST_REL,
      ST_RET
   } ebr_state_t;

   localparam int CMD_W = 3;
   localparam logic [CMD_W-1:0] CMD_NOP  = 3'b111;
   localparam logic [CMD_W-1:0] CMD_PALL = 3'b010;
endpackage

// File: rtl/ebr_fsm.sv
module ebr_fsm
   import ebr_pkg::*;
#(
   parameter int POST_NOPS = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             breq_n,
   input  logic             access_busy,
   output logic             released,
   output logic             bus_oe,
   output logic [CMD_W-1:0] cmd
);
   localparam int CNT_W = (POST_NOPS < 2) ? 1 : $clog2(POST_NOPS);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(POST_NOPS - 1);

   ebr_state_t       st_q, st_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;

   always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q;
      unique case (st_q)
         ST_IDLE: if (!breq_n) st_d = ST_WAIT;
         ST_WAIT: if (!access_busy) st_d = ST_PALL;
         ST_PALL: begin
            st_d  = ST_POST;
            cnt_d = '0;
         end
         ST_POST: begin
            if (cnt_q == CNT_LAST) st_d = ST_REL;
            else                   cnt_d = cnt_q + 1'b1;
         end
         ST_REL:  if (breq_n) st_d = ST_RET;
         ST_RET:  st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
      end
   end

   assign released = (st_q == ST_REL);
   assign bus_oe   = !((st_q == ST_REL) || (st_q == ST_RET));
   assign cmd      = (st_q == ST_PALL) ? CMD_PALL : CMD_NOP;
endmodule

// File: rtl/ebr_reqout.sv
module ebr_reqout #(
   parameter bit HALF_STATE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic released,
   input  logic reqout_en,
   input  logic int_access_req,
   input  logic refresh_req,
   input  logic refresh_start,
   output logic reqout_n
);
   logic req_q, hold_q, out_q;
   logic req_d, hold_d;

   always_comb begin
      hold_d = !refresh_start &&
               ((reqout_en && released && refresh_req) || hold_q);
      req_d  = reqout_en &&
               ((released && (int_access_req || refresh_req)) ||
                (hold_q && !refresh_start));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= 1'b0;
         hold_q <= 1'b0;
      end else begin
         req_q  <= req_d;
         hold_q <= hold_d;
      end
   end

   generate
      if (HALF_STATE) begin : g_half
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) out_q <= 1'b0;
            else        out_q <= req_q;
         end
      end else begin : g_full
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_q <= 1'b0;
            else        out_q <= req_q;
         end
      end
   endgenerate

   assign reqout_n = !out_q;
endmodule

// File: rtl/ext_bus_release.sv
module ext_bus_release
   import ebr_pkg::*;
#(
   parameter int POST_NOPS  = 1,
   parameter bit HALF_STATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             breq_n,
   input  logic             access_busy,
   input  logic             int_access_req,
   input  logic             refresh_req,
   input  logic             refresh_start,
   input  logic             reqout_en,
   output logic             back_n,
   output logic             reqout_n,
   output logic             bus_oe,
   output logic [CMD_W-1:0] sdram_cmd
);
   generate
      if (POST_NOPS < 1 || POST_NOPS > 64) begin : g_bad_post
         $error("ext_bus_release: POST_NOPS must lie in 1..64");
      end
   endgenerate

   logic released;

   ebr_fsm #(.POST_NOPS(POST_NOPS)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .breq_n      (breq_n),
      .access_busy (access_busy),
      .released    (released),
      .bus_oe      (bus_oe),
      .cmd         (sdram_cmd)
   );

   ebr_reqout #(.HALF_STATE(HALF_STATE)) u_req (
      .clk            (clk),
      .rst_n          (rst_n),
      .released       (released),
      .reqout_en      (reqout_en),
      .int_access_req (int_access_req),
      .refresh_req    (refresh_req),
      .refresh_start  (refresh_start),
      .reqout_n       (reqout_n)
   );

   assign back_n = !released;
endmodule

// File: rtl/ebr_checker.sv
module ebr_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       breq_n,
   input logic       access_busy,
   input logic       reqout_en,
   input logic       back_n,
   input logic       reqout_n,
   input logic       bus_oe,
   input logic [2:0] sdram_cmd
);
   logic pall_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     pall_seen <= 1'b0;
      else if (sdram_cmd == 3'b010)   pall_seen <= 1'b1;
      else if (!back_n)               pall_seen <= 1'b0;
   end

   a_r2_pall_after_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
      (sdram_cmd == 3'b010) |-> !$past(access_busy));

   a_r3_pall_before_release: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(back_n) |-> (pall_seen && $past(sdram_cmd) == 3'b111));

   a_r3_two_driven_states: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(back_n) |-> ($past(bus_oe) && $past(back_n, 2)));

   a_r4_hiz_when_released: assert property (@(posedge clk) disable iff (!rst_n)
      !back_n |-> !bus_oe);

   a_r5_hold_while_requested: assert property (@(posedge clk) disable iff (!rst_n)
      (!back_n && !breq_n) |=> !back_n);

   a_r5_reenable_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_oe) |-> (back_n && $past(back_n)));

   a_r9_disabled_reqout: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(reqout_en) |-> reqout_n);
endmodule

bind ext_bus_release ebr_checker u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .breq_n      (breq_n),
   .access_busy (access_busy),
   .reqout_en   (reqout_en),
   .back_n      (back_n),
   .reqout_n    (reqout_n),
   .bus_oe      (bus_oe),
   .sdram_cmd   (sdram_cmd)
);

// File: tb/sim_ext_bus_release.sv
`timescale 1ns/1ps
module sim_ext_bus_release;
   localparam int POST = 1;
   localparam logic [2:0] NOP  = 3'b111;
   localparam logic [2:0] PALL = 3'b010;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic breq_n = 1'b1, access_busy = 1'b0, int_access_req = 1'b0;
   logic refresh_req = 1'b0, refresh_start = 1'b0, reqout_en = 1'b0;
   logic back_n, reqout_n, bus_oe;
   logic [2:0] sdram_cmd;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   ext_bus_release #(.POST_NOPS(POST), .HALF_STATE(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .breq_n(breq_n), .access_busy(access_busy),
      .int_access_req(int_access_req), .refresh_req(refresh_req),
      .refresh_start(refresh_start), .reqout_en(reqout_en),
      .back_n(back_n), .reqout_n(reqout_n), .bus_oe(bus_oe),
      .sdram_cmd(sdram_cmd)
   );

   task automatic chk(string req, logic [5:0] got, logic [5:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b", req, got, exp);
      end
   endtask

   // {back_n, bus_oe, cmd}
   function automatic logic [5:0] bus_v();
      return {1'b0, back_n, bus_oe, sdram_cmd};
   endfunction
   function automatic logic [5:0] bus_e(logic b, logic o, logic [2:0] c);
      return {1'b0, b, o, c};
   endfunction

   task automatic run_case(int k, bit en, int mode);
      bit lowx;
      lowx = en && (mode != 0);
      reqout_en = en;
      @(posedge clk); #2;
      breq_n = 1'b0;
      access_busy = (k > 0);
      for (int n = 0; n <= k + 2 + POST; n++) begin
         @(posedge clk); #2;
         if (n == k) access_busy = 1'b0;
         #3;
         if (n <= k)
            chk("R2 wait for access", bus_v(), bus_e(1'b1, 1'b1, NOP));
         else if (n == k + 1)
            chk("R2 PALL issued", bus_v(), bus_e(1'b1, 1'b1, PALL));
         else if (n < k + 2 + POST)
            chk("R3 NOP after PALL", bus_v(), bus_e(1'b1, 1'b1, NOP));
         else
            chk("R3 R4 released and high-Z", bus_v(), bus_e(1'b0, 1'b0, NOP));
      end
      int_access_req = (mode == 1);
      refresh_req    = (mode == 2);
      @(posedge clk); #15;
      chk("R6 R9 reqout asserted", {5'b0, reqout_n}, {5'b0, !lowx});
      refresh_req = 1'b0;
      @(posedge clk); #2;
      breq_n = 1'b1;
      #13;
      chk("R5 still released", {4'b0, back_n, reqout_n}, {4'b0, 1'b0, !lowx});
      @(posedge clk); #5;
      chk("R5 ack high, drivers off", bus_v(), bus_e(1'b1, 1'b0, NOP));
      @(posedge clk); #5;
      chk("R5 drivers back on", bus_v(), bus_e(1'b1, 1'b1, NOP));
      chk("R7 reqout low before 1.5", {5'b0, reqout_n}, {5'b0, !lowx});
      #10;
      if (mode == 2)
         chk("R8 refresh hold", {5'b0, reqout_n}, {5'b0, !en});
      else
         chk("R7 reqout high at 1.5", {5'b0, reqout_n}, 6'd1);
      if (mode == 2) begin
         @(posedge clk);
         @(posedge clk); #15;
         chk("R8 held until refresh start", {5'b0, reqout_n}, {5'b0, !en});
         refresh_start = 1'b1;
         @(posedge clk); #2;
         refresh_start = 1'b0;
         #13;
         chk("R8 released by refresh start", {5'b0, reqout_n}, 6'd1);
      end
      int_access_req = 1'b0;
      for (int i = 0; i < 2; i++) begin
         @(posedge clk); #15;
         chk("R1 idle with breq high", {bus_v()[4:0], reqout_n},
             {bus_e(1'b1, 1'b1, NOP)[4:0], 1'b1});
      end
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      #35;
      chk("R10 reset state", {bus_v()[4:0], reqout_n},
          {bus_e(1'b1, 1'b1, NOP)[4:0], 1'b1});
      rst_n = 1'b1;
      // R9: pending requests with enable low and bus idle leave reqout high
      int_access_req = 1'b1;
      refresh_req = 1'b1;
      repeat (3) @(posedge clk);
      #15;
      chk("R9 R1 idle requests ignored", {bus_v()[4:0], reqout_n},
          {bus_e(1'b1, 1'b1, NOP)[4:0], 1'b1});
      int_access_req = 1'b0;
      refresh_req = 1'b0;
      for (int k = 0; k < 4; k++)
         for (int en = 0; en < 2; en++)
            for (int mode = 0; mode < 3; mode++)
               run_case(k, en[0], mode);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule